// File: doc/BRIEF.md
# Register-State Image Loader

This block is a load sequencer for a 16-bit segmented processor model. When it is triggered, it fetches a fixed 102-byte state image from memory through a 16-bit read port, one little-endian word per accepted read. The image starts at physical address 000800h. Each word lands in its slot in the architectural register file or in one of eight six-byte hidden descriptor caches. Words that carry no state are fetched and dropped.

The caches are filled straight from the image, whatever the visible selectors hold. They are then used exactly as loaded. The block derives the current privilege level and a validity flag for each cache from what was loaded. A probe port lets the surrounding model test an access through any cache: an access through an entry whose valid flag is clear reports general-protection vector 0Dh. An ordinary segment-register write, accepted only while no load is running, replaces a selector and its cache together.

Top module: `state_image_loader`

## Requirements
- R1: A load issues `mem_req_o` with address BASE_ADDR (default 000800h) and steps the address by 2 after each cycle in which `mem_valid_i` is high, 51 reads in all. The address is held while valid is low.
- R2: Image word 3 (byte offset 06h) loads `regs_o[0]` (machine status word). Words 0–2 and 4–10 change no output.
- R3: Words 11 to 26 load `regs_o[1]`..`regs_o[16]`, in this order: task register, flags, instruction pointer, local table selector, DS, SS, CS, ES, DI, SI, BP, SP, BX, DX, CX, AX.
- R4: Words 27 to 50 fill caches 0..7, in the order ES, CS, SS, DS, global table, local table, interrupt table, task state, three words per cache. The first word is base[15:0]. The second word has the rights byte in its high byte and base[23:16] in its low byte. The third word is the limit. `cache_o[e]` packs {limit[47:32], rights[31:24], base[23:0]}.
- R5: Caches keep their loaded values, even where they disagree with the selectors, until the next load or segment write.
- R6: Let the final word be accepted at clock edge E. `done_o` is then high for exactly one cycle, from edge E+1 to edge E+2.
- R7: `cpl_o` equals bits 6:5 of the CS cache rights byte. `cpl_split_o` is high when the SS cache holds a different value in those bits.
- R8: `cache_valid_o[e]` is bit 7 of cache e's rights byte. A probe in cycle N sets `fault_o`, with `fault_code_o` = 0Dh, in cycle N+1 when the probed entry is invalid. Otherwise `fault_o` is low and the code is 00h.
- R9: When idle, a segment write with index i (0 ES, 1 CS, 2 SS, 3 DS) stores the selector in `regs_o[8-i]` and the descriptor in cache i at the same edge.
- R10: While a load runs, both `start_i` and `seg_wr_i` are ignored.
- R11: `tbl_ar_err_o` is high while the rights byte of the global-table cache (4) or of the interrupt-table cache (6) is non-zero.
- R12: After reset, all registers and caches are zero, no read is pending and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load when idle |
| mem_req_o | output | 1 | Read request, high during a load |
| mem_addr_o | output | ADDR_W | Byte address of the word requested |
| mem_rdata_i | input | 16 | Read word, little-endian |
| mem_valid_i | input | 1 | Read word is valid this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| seg_wr_i | input | 1 | Normal segment-register write |
| seg_wr_idx_i | input | 2 | Segment: 0 ES, 1 CS, 2 SS, 3 DS |
| seg_wr_sel_i | input | 16 | Selector value to write |
| seg_wr_desc_i | input | 48 | Descriptor {limit, rights, base} for the cache |
| probe_i | input | 1 | Access attempt through a cache |
| probe_idx_i | input | 3 | Cache probed |
| fault_o | output | 1 | Access faulted (registered) |
| fault_code_o | output | 8 | 0Dh on fault, else 00h |
| regs_o | output | 17x16 | Register file, index order of R2/R3 |
| cache_o | output | 8x48 | Descriptor caches, order of R4 |
| cache_valid_o | output | 8 | Present bit of each cache |
| cpl_o | output | 2 | Current privilege level |
| cpl_split_o | output | 1 | SS and CS privilege levels differ |
| tbl_ar_err_o | output | 1 | Descriptor-table rights byte not zero |

## Verification
The bench builds the block with its default parameters: a 24-bit address and a base of 000800h. This places the image at its fixed location and makes the full 51-word address walk, including the last address, visible at the ports. Read latency is varied between zero and three wait cycles, so that both back-to-back acceptance and held requests are covered. Two images with different rights bytes drive the privilege, split, table-error and fault paths to both of their values.

// File: rtl/sil_pkg.sv
package sil_pkg;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned IMG_BYTES   = 102;
  localparam int unsigned IMG_WORDS   = IMG_BYTES / 2;
  localparam int unsigned IDX_W       = $clog2(IMG_WORDS);
  localparam int unsigned MSW_WORD    = 3;
  localparam int unsigned GPR_WORD0   = 11;
  localparam int unsigned NREGS       = 17;
  localparam int unsigned CACHE_WORD0 = GPR_WORD0 + NREGS - 1;
  localparam int unsigned WORDS_PER_C = 3;
  localparam int unsigned NCACHE      = 8;
  localparam int unsigned NSEG        = 4;
  localparam int unsigned ES_REG      = 8;
  localparam logic [7:0]  GP_VECTOR   = 8'h0D;

  typedef struct packed {
    logic [15:0] limit;
    logic [7:0]  rights;
    logic [23:0] base;
  } desc_t;

  typedef enum logic {ST_IDLE, ST_LOAD} fsm_e;

  function automatic int unsigned reg_word(input int unsigned r);
    return (r == 0) ? MSW_WORD : GPR_WORD0 + r - 1;
  endfunction
endpackage

// File: rtl/sil_fetch.sv
module sil_fetch
  import sil_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h000800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_WORDS - 1);

  fsm_e             state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             fin_q, fin_d;
  logic             done_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    fin_d   = 1'b0;
    wr_en_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOAD;
          idx_d   = '0;
        end
      end
      ST_LOAD: begin
        if (mem_valid_i) begin
          wr_en_o = 1'b1;
          if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
            fin_d   = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fin_q   <= fin_d;
      done_q  <= fin_q;
    end
  end

  assign mem_req_o  = (state_q == ST_LOAD);
  assign mem_addr_o = BASE_ADDR + ADDR_W'({idx_q, 1'b0});
  assign wr_idx_o   = idx_q;
  assign wr_data_o  = mem_rdata_i;
  assign done_o     = done_q;
endmodule

// File: rtl/sil_store.sv
module sil_store
  import sil_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         seg_wr_i,
  input  logic [1:0]                   seg_idx_i,
  input  logic [DATA_W-1:0]            seg_sel_i,
  input  desc_t                        seg_desc_i,
  output logic [NREGS-1:0][DATA_W-1:0] regs_o,
  output desc_t [NCACHE-1:0]           cache_o
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    localparam int unsigned SRC = reg_word(r);
    logic              load_hit, seg_hit;
    logic [DATA_W-1:0] val_q;

    assign load_hit = wr_en_i && (wr_idx_i == IDX_W'(SRC));
    if (r >= ES_REG - NSEG + 1 && r <= ES_REG) begin : g_seg
      assign seg_hit = seg_wr_i && (seg_idx_i == 2'(ES_REG - r));
    end else begin : g_noseg
      assign seg_hit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        val_q <= '0;
      else if (load_hit) val_q <= wr_data_i;
      else if (seg_hit)  val_q <= seg_sel_i;
    end
    assign regs_o[r] = val_q;
  end

  for (genvar e = 0; e < NCACHE; e++) begin : g_cache
    localparam int unsigned W0 = CACHE_WORD0 + WORDS_PER_C * e;
    logic  hit_lo, hit_mid, hit_lim, seg_hit;
    desc_t ent_q;

    assign hit_lo  = wr_en_i && (wr_idx_i == IDX_W'(W0));
    assign hit_mid = wr_en_i && (wr_idx_i == IDX_W'(W0 + 1));
    assign hit_lim = wr_en_i && (wr_idx_i == IDX_W'(W0 + 2));
    if (e < NSEG) begin : g_seg
      assign seg_hit = seg_wr_i && (seg_idx_i == 2'(e));
    end else begin : g_noseg
      assign seg_hit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (seg_hit) begin
        ent_q <= seg_desc_i;
      end else begin
        if (hit_lo)  ent_q.base[15:0]              <= wr_data_i;
        if (hit_mid) {ent_q.rights, ent_q.base[23:16]} <= wr_data_i;
        if (hit_lim) ent_q.limit                   <= wr_data_i;
      end
    end
    assign cache_o[e] = ent_q;
  end
endmodule

// File: rtl/state_image_loader.sv
module state_image_loader
  import sil_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h000800
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  output logic                         mem_req_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  input  logic [15:0]                  mem_rdata_i,
  input  logic                         mem_valid_i,
  output logic                         done_o,
  input  logic                         seg_wr_i,
  input  logic [1:0]                   seg_wr_idx_i,
  input  logic [15:0]                  seg_wr_sel_i,
  input  logic [47:0]                  seg_wr_desc_i,
  input  logic                         probe_i,
  input  logic [2:0]                   probe_idx_i,
  output logic                         fault_o,
  output logic [7:0]                   fault_code_o,
  output logic [16:0][15:0]            regs_o,
  output logic [7:0][47:0]             cache_o,
  output logic [7:0]                   cache_valid_o,
  output logic [1:0]                   cpl_o,
  output logic                         cpl_split_o,
  output logic                         tbl_ar_err_o
);
  localparam int unsigned CS_C = 1, SS_C = 2, GDT_C = 4, IDT_C = 6;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              seg_go;
  desc_t [NCACHE-1:0] cache_w;
  logic              fault_d, fault_q;

  sil_fetch #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .done_o      (done_o)
  );

  assign seg_go = seg_wr_i && !mem_req_o;

  sil_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .seg_wr_i   (seg_go),
    .seg_idx_i  (seg_wr_idx_i),
    .seg_sel_i  (seg_wr_sel_i),
    .seg_desc_i (desc_t'(seg_wr_desc_i)),
    .regs_o     (regs_o),
    .cache_o    (cache_w)
  );

  for (genvar e = 0; e < NCACHE; e++) begin : g_out
    assign cache_o[e]       = cache_w[e];
    assign cache_valid_o[e] = cache_w[e].rights[7];
  end

  assign cpl_o        = cache_w[CS_C].rights[6:5];
  assign cpl_split_o  = cache_w[CS_C].rights[6:5] != cache_w[SS_C].rights[6:5];
  assign tbl_ar_err_o = (|cache_w[GDT_C].rights) || (|cache_w[IDT_C].rights);

  always_comb fault_d = probe_i && !cache_w[probe_idx_i].rights[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault_o      = fault_q;
  assign fault_code_o = fault_q ? GP_VECTOR : 8'h00;
endmodule

// File: rtl/sil_checker.sv
module sil_checker #(
  parameter int unsigned      ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h000800
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic              done_o,
  input logic              seg_wr_i,
  input logic              probe_i,
  input logic [2:0]        probe_idx_i,
  input logic              fault_o,
  input logic [7:0]        fault_code_o,
  input logic [7:0][47:0]  cache_o,
  input logic [7:0]        cache_valid_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(100);

  // R1: a load opens at the base address
  a_r1_base_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o) |-> mem_addr_o == BASE_ADDR);

  // R1: each accepted word advances the address by one word
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_valid_i && mem_addr_o != LAST_ADDR)
      |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)));

  // R1: request and address held while no word arrives
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R6: done follows the final accepted word after one more edge
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_valid_i && mem_addr_o == LAST_ADDR) |=> ##1 done_o);

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: caches hold while idle with no segment write
  a_r5_cache_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_o && !seg_wr_i) |=> $stable(cache_o));

  // R8: a fault always carries the protection vector
  a_r8_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> fault_code_o == 8'h0D);

  // R8: probing a valid entry never faults
  a_r8_valid_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_i && cache_valid_o[probe_idx_i]) |=> !fault_o);
endmodule

bind state_image_loader sil_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_sil_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_valid_i   (mem_valid_i),
  .done_o        (done_o),
  .seg_wr_i      (seg_wr_i),
  .probe_i       (probe_i),
  .probe_idx_i   (probe_idx_i),
  .fault_o       (fault_o),
  .fault_code_o  (fault_code_o),
  .cache_o       (cache_o),
  .cache_valid_o (cache_valid_o)
);

// File: tb/test_state_image_loader.sv
`timescale 1ns/1ps
module test_state_image_loader;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start_i, mem_valid_i, seg_wr_i, probe_i;
  logic [15:0] mem_rdata_i, seg_wr_sel_i;
  logic [1:0]  seg_wr_idx_i;
  logic [47:0] seg_wr_desc_i;
  logic [2:0]  probe_idx_i;
  logic        mem_req_o, done_o, fault_o, cpl_split_o, tbl_ar_err_o;
  logic [23:0] mem_addr_o;
  logic [7:0]  fault_code_o, cache_valid_o;
  logic [16:0][15:0] regs_o;
  logic [7:0][47:0]  cache_o;
  logic [1:0]  cpl_o;

  state_image_loader i_state_image_loader (.*);

  int    n_cmp = 0, n_bad = 0;
  string tag = "R12";
  logic [7:0] img [0:101];
  int    lat = 0, wcnt = 0;
  bit    finished = 0;

  // reference model state
  logic [15:0] m_regs [0:16];
  logic [47:0] m_cache [0:7];
  bit    m_busy, m_fin, m_done, m_fault;
  int    m_idx;

  task automatic put_word(input int w, input logic [15:0] d);
    if (w == 3) m_regs[0] = d;
    else if (w >= 11 && w <= 26) m_regs[w - 10] = d;
    else if (w >= 27) begin
      int e = (w - 27) / 3;
      int p = (w - 27) % 3;
      if (p == 0) m_cache[e][15:0] = d;
      else if (p == 1) m_cache[e][31:16] = d;
      else m_cache[e][47:32] = d;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 17; i++) m_regs[i] = '0;
      for (int i = 0; i < 8; i++) m_cache[i] = '0;
      m_busy = 0; m_fin = 0; m_done = 0; m_fault = 0; m_idx = 0;
    end else begin
      m_done  = m_fin;
      m_fin   = 0;
      m_fault = probe_i && !m_cache[probe_idx_i][31];
      if (m_busy) begin
        if (mem_valid_i) begin
          put_word(m_idx, mem_rdata_i);
          if (m_idx == 50) begin m_busy = 0; m_fin = 1; end
          else m_idx++;
        end
      end else begin
        if (seg_wr_i) begin
          m_regs[8 - seg_wr_idx_i] = seg_wr_sel_i;
          m_cache[seg_wr_idx_i]    = seg_wr_desc_i;
        end
        if (start_i) begin m_busy = 1; m_idx = 0; end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: got %h expected %h at %0t", req, tag, what, got, exp, $time);
    end
  endtask

  // compare on every clock, then drive the memory reply
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "mem_req", mem_req_o, m_busy);
      if (m_busy) chk("R1", "mem_addr", mem_addr_o, 24'h800 + 2 * m_idx);
      chk("R6", "done", done_o, m_done);
      for (int i = 0; i < 17; i++) chk(i == 0 ? "R2" : "R3", $sformatf("reg%0d", i), regs_o[i], m_regs[i]);
      for (int e = 0; e < 8; e++) begin
        chk("R4", $sformatf("cache%0d", e), cache_o[e], m_cache[e]);
        chk("R8", $sformatf("valid%0d", e), cache_valid_o[e], m_cache[e][31]);
      end
      chk("R7", "cpl", cpl_o, m_cache[1][30:29]);
      chk("R7", "cpl_split", cpl_split_o, m_cache[1][30:29] != m_cache[2][30:29]);
      chk("R11", "tbl_ar_err", tbl_ar_err_o, (m_cache[4][31:24] != 0) || (m_cache[6][31:24] != 0));
      chk("R8", "fault", fault_o, m_fault);
      chk("R8", "fault_code", fault_code_o, m_fault ? 8'h0D : 8'h00);
    end
    if (mem_req_o && wcnt >= lat) begin
      int a = int'(mem_addr_o) - 'h800;
      mem_valid_i = 1'b1;
      mem_rdata_i = (a >= 0 && a < 101) ? {img[a + 1], img[a]} : 16'hDEAD;
      wcnt = 0;
    end else begin
      mem_valid_i = 1'b0;
      mem_rdata_i = 16'h5A5A;
      if (mem_req_o) wcnt++;
    end
  end

  task automatic build_image(input int seed, input logic [7:0] ar [0:7]);
    for (int i = 0; i < 102; i++) img[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 2));
    for (int e = 0; e < 8; e++) img['h36 + 6 * e + 3] = ar[e];
  endtask

  task automatic wait_done();
    for (int k = 0; k < 2000 && !done_o; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic probe_all();
    for (int e = 0; e < 8; e++) begin
      probe_i = 1'b1; probe_idx_i = 3'(e); @(negedge clk);
    end
    probe_i = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog [%s]: run did not finish, got hung expected done", tag);
    finish_run();
  end

  initial begin
    logic [7:0] ar1 [0:7] = '{8'h93, 8'hFB, 8'hF3, 8'h13, 8'h00, 8'h82, 8'h00, 8'h81};
    logic [7:0] ar2 [0:7] = '{8'h13, 8'h9B, 8'hD3, 8'h93, 8'h05, 8'h02, 8'h00, 8'h89};
    rst_n = 0; start_i = 0; seg_wr_i = 0; probe_i = 0; probe_idx_i = 0;
    seg_wr_idx_i = 0; seg_wr_sel_i = 0; seg_wr_desc_i = 0;
    mem_valid_i = 0; mem_rdata_i = 0;
    build_image(1, ar1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);      // R12 reset state compared here
    tag = "R8 after reset";
    probe_all();

    // first load, one wait cycle per word; R2 skipped words carry nonzero data
    tag = "R1 R2 R3 R4"; lat = 1;
    pulse_start();
    repeat (20) @(negedge clk);
    tag = "R10 start and segment write mid-load";
    start_i = 1; seg_wr_i = 1; seg_wr_idx_i = 1; seg_wr_sel_i = 16'hBEEF;
    seg_wr_desc_i = 48'h1234_9B_ABCDEF;
    @(negedge clk);
    start_i = 0; seg_wr_i = 0;
    tag = "R6 completion";
    wait_done();
    tag = "R8 R7 probes image 1";
    probe_all();

    // R9 segment writes, then R5 hold
    tag = "R9 segment write";
    for (int s = 0; s < 4; s++) begin
      seg_wr_i = 1; seg_wr_idx_i = 2'(s); seg_wr_sel_i = 16'(16'h1000 + s);
      seg_wr_desc_i = {16'(16'hF000 + s), 8'(8'h80 | (s << 5)), 24'(24'h0A0000 + s)};
      @(negedge clk);
    end
    seg_wr_i = 0;
    tag = "R5 idle hold";
    repeat (6) @(negedge clk);
    probe_all();

    // second image, back-to-back words, table rights non-zero
    tag = "R11 image 2 zero latency"; lat = 0;
    build_image(7, ar2);
    pulse_start();
    wait_done();
    tag = "R7 R8 probes image 2";
    probe_all();

    // third load with long waits
    tag = "R1 three wait cycles"; lat = 3;
    build_image(3, ar1);
    pulse_start();
    wait_done();
    probe_all();
    finish_run();
  end
endmodule